// File: doc/BRIEF.md
# Converter Serial Output Sequencer

This block is the digital control side of a cyclic sampling converter. It goes round three states on its own: `CONVERT`, which is modelled as a fixed count of system clock cycles; `SLEEP`, which holds the latched result; and `OUTPUT`, which shifts a 24-bit word out on a serial data line. An external active-low chip select and a shift clock steer it. There are no registers to program. The chip select alone decides whether the block sleeps, shows its status, or outputs data.

Both pins are asynchronous to the system clock. Each passes through a two-flop synchroniser with edge detection. The serial line is modelled as a data bit `sdo_d` plus an enable `sdo_oe`, which together stand for a three-state driver. The line is enabled only while the synchronised chip select is low.

The state transitions are:
- `CONVERT` to `SLEEP` when the cycle count completes. The result is latched at this point.
- `SLEEP` to `OUTPUT` when chip select is low.
- `OUTPUT` to `CONVERT` after the 24th falling shift-clock edge.
- `OUTPUT` to `CONVERT` at once if chip select returns high (abort).

Reset places the block in `CONVERT`.

Top module: `conv_seq`

## Requirements
- R1: While reset is asserted and after it is released, the state is `CONVERT` and `sdo_oe` is 0 until the synchronised chip select goes low.
- R2: A conversion lasts exactly `CONV_CYCLES` system clock cycles from its start. The bench observes this as the number of cycles `sdo_d` shows busy (1) after reset.
- R3: The result, sign and range inputs are sampled only on the cycle the conversion ends. The latched word is held unchanged through `SLEEP`, whatever the inputs do.
- R4: In `SLEEP`, a low chip select moves the block to `OUTPUT` on the next cycle, presenting bit 23 of the word.
- R5: The output word is `{eoc, 1'b0, sign, range, result[19:0]}`, sent bit 23 first down to bit 0.
- R6: The serial bit advances only on a synchronised falling edge of the shift clock. A rising edge leaves it unchanged.
- R7: After the 24th falling edge in `OUTPUT`, the block returns to `CONVERT`.
- R8: A rise of chip select while in `OUTPUT` aborts the transfer and starts a new conversion.
- R9: `sdo_oe` equals the inverse of the synchronised chip select.
- R10: While enabled, `sdo_d` is 1 in `CONVERT` and 0 in `SLEEP`.
- R11: The `eoc` bit (bit 23) is 1 in the first word after reset and 0 in every later word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select, asynchronous |
| sck | input | 1 | Shift clock, asynchronous; data advances on its fall |
| res_in | input | RES_W | Conversion result to latch |
| sign_in | input | 1 | Sign flag to latch |
| range_in | input | 1 | Extended-range flag to latch |
| sdo_d | output | 1 | Serial data / status bit |
| sdo_oe | output | 1 | Output enable of the serial line (0 = high impedance) |

## Verification
The bench sweeps many result, sign and range patterns through full conversion and readout cycles. Each expected word is built arithmetically, so a field placed at the wrong position, or a result shifted LSB-first, shows up as a miscompare. Between the end of each conversion and the readout, the bench changes the inputs. A design that samples them late, or keeps tracking them during sleep, would shift out the new values. The bench also checks the serial bit after every shift-clock rise, which catches a shifter that steps on the wrong edge. It counts the busy cycles after reset, which catches an off-by-one in the conversion counter. Finally, it aborts a transfer part-way and then looks for busy status and a fresh word; a design that ignored the abort would keep shifting the old word.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
    typedef enum logic [1:0] {
        ST_CONVERT = 2'd0,
        ST_SLEEP   = 2'd1,
        ST_OUTPUT  = 2'd2
    } seq_state_e;

    localparam int STATUS_W = 4;
endpackage

// File: rtl/pin_sync_edge.sv
module pin_sync_edge #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic rise,
    output logic fall
);
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= RST_VAL;
            s2_q <= RST_VAL;
            s3_q <= RST_VAL;
        end else begin
            s1_q <= pin;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign level = s2_q;
    assign rise  = s2_q & ~s3_q;
    assign fall  = ~s2_q & s3_q;
endmodule

// File: rtl/conv_timer.sv
module conv_timer #(
    parameter int CONV_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(CONV_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    assign done = run && (cnt_q == CW'(CONV_CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || done) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2: the count never passes the conversion length
    a_r2_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(CONV_CYCLES));
endmodule

// File: rtl/word_shifter.sv
module word_shifter #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    input  logic              start,
    input  logic              step,
    output logic              bit_out,
    output logic              last
);
    localparam int IW = $clog2(WORD_W);

    logic [WORD_W-1:0] word_q;
    logic [IW-1:0]     idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (load) begin
            word_q <= word_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= IW'(WORD_W - 1);
        end else if (start) begin
            idx_q <= IW'(WORD_W - 1);
        end else if (step && idx_q != '0) begin
            idx_q <= idx_q - 1'b1;
        end
    end

    assign bit_out = word_q[idx_q];
    assign last    = (idx_q == '0);

    // R3: the latched word only changes on a load
    a_r3_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(word_q));
    // R6: the bit index moves only on a step or a restart
    a_r6_idx_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !start) |=> $stable(idx_q));
endmodule

// File: rtl/conv_seq.sv
module conv_seq
    import conv_seq_pkg::*;
#(
    parameter int RES_W       = 20,
    parameter int CONV_CYCLES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sck,
    input  logic [RES_W-1:0] res_in,
    input  logic             sign_in,
    input  logic             range_in,
    output logic             sdo_d,
    output logic             sdo_oe
);
    localparam int WORD_W = RES_W + STATUS_W;

    seq_state_e state_q, state_d;

    logic cs_lvl, cs_rise, cs_fall_unused;
    logic sck_lvl_unused, sck_rise_unused, sck_fall;
    logic conv_done, shift_bit, shift_last;
    logic first_q;
    logic start_out, step_out;

    pin_sync_edge #(.RST_VAL(1'b1)) u_cs_sync (
        .clk(clk), .rst_n(rst_n), .pin(cs_n),
        .level(cs_lvl), .rise(cs_rise), .fall(cs_fall_unused)
    );

    pin_sync_edge #(.RST_VAL(1'b0)) u_sck_sync (
        .clk(clk), .rst_n(rst_n), .pin(sck),
        .level(sck_lvl_unused), .rise(sck_rise_unused), .fall(sck_fall)
    );

    conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .run(state_q == ST_CONVERT),
        .done(conv_done)
    );

    assign start_out = (state_q == ST_SLEEP) && !cs_lvl;
    assign step_out  = (state_q == ST_OUTPUT) && !cs_lvl && sck_fall;

    word_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .load(conv_done),
        .word_in({first_q, 1'b0, sign_in, range_in, res_in}),
        .start(start_out),
        .step(step_out),
        .bit_out(shift_bit),
        .last(shift_last)
    );

    // first-result-after-reset flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q <= 1'b1;
        end else if (conv_done) begin
            first_q <= 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CONVERT;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CONVERT: if (conv_done) state_d = ST_SLEEP;
            ST_SLEEP:   if (!cs_lvl)   state_d = ST_OUTPUT;
            ST_OUTPUT: begin
                if (cs_lvl)                      state_d = ST_CONVERT;
                else if (sck_fall && shift_last) state_d = ST_CONVERT;
            end
            default:                             state_d = ST_CONVERT;
        endcase
    end

    // outputs
    always_comb begin
        sdo_oe = !cs_lvl;
        unique case (state_q)
            ST_CONVERT: sdo_d = 1'b1;
            ST_SLEEP:   sdo_d = 1'b0;
            ST_OUTPUT:  sdo_d = shift_bit;
            default:    sdo_d = 1'b1;
        endcase
    end

    // R4: sleep with chip select low leads straight to output
    a_r4_sleep_to_out: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && !cs_lvl) |=> state_q == ST_OUTPUT);
    // R7: final falling edge ends the transfer
    a_r7_end_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OUTPUT && !cs_lvl && sck_fall && shift_last) |=> state_q == ST_CONVERT);
    // R8: chip select rise aborts output
    a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OUTPUT && cs_rise) |=> state_q == ST_CONVERT);
    // R3: sleep is left only through output
    a_r3_sleep_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP) |=> (state_q == ST_SLEEP || state_q == ST_OUTPUT));
    // R2: conversion ends only when the timer completes
    a_r2_convert_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONVERT && !conv_done) |=> state_q == ST_CONVERT);
endmodule

// File: tb/conv_seq_test.sv
module conv_seq_test;
    localparam int RES_W = 20;
    localparam int N     = 20;
    localparam int W     = RES_W + 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b0;
    logic sck = 1'b0;
    logic [RES_W-1:0] res_in = 20'hA5C3F;
    logic sign_in = 1'b1;
    logic range_in = 1'b0;
    logic sdo_d, sdo_oe;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    conv_seq #(.RES_W(RES_W), .CONV_CYCLES(N)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
        .res_in(res_in), .sign_in(sign_in), .range_in(range_in),
        .sdo_d(sdo_d), .sdo_oe(sdo_oe)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic read_word(output logic [W-1:0] w);
        for (int i = W - 1; i >= 0; i--) begin
            w[i] = sdo_d;
            sck = 1'b1;
            wait_clk(4);
            check("R6 bit stable across rise", 32'(sdo_d), 32'(w[i]));
            sck = 1'b0;
            wait_clk(4);
        end
    endtask

    function automatic logic [W-1:0] mk_word(input logic eoc, input logic s,
                                             input logic r, input logic [RES_W-1:0] v);
        return {eoc, 1'b0, s, r, v};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] got;
        int busy;
        logic [RES_W-1:0] v;
        logic s, r;

        // R1: reset state, line disabled while in reset
        wait_clk(3);
        check("R1 oe in reset", 32'(sdo_oe), 32'd0);
        check("R1 busy in reset", 32'(sdo_d), 32'd1);
        rst_n = 1'b1;

        // R2: busy cycles after reset (samples after edges 1..N-1)
        busy = 0;
        for (int k = 0; k < 3 * N; k++) begin
            @(negedge clk);
            if (sdo_d == 1'b1) busy++;
            else break;
        end
        check("R2 conversion length", 32'(busy), 32'(N - 1));
        check("R10 sleep status low", 32'(sdo_d), 32'd0);
        check("R9 oe with cs low", 32'(sdo_oe), 32'd1);
        wait_clk(1);
        // R4 R11: first word flags invalid result
        read_word(got);
        check("R11 first word", 32'(got), 32'(mk_word(1'b1, 1'b1, 1'b0, 20'hA5C3F)));
        wait_clk(4);
        check("R7 busy after 24 bits", 32'(sdo_d), 32'd1);
        cs_n = 1'b1;
        wait_clk(4);
        check("R9 oe with cs high", 32'(sdo_oe), 32'd0);

        // R3 R5: pattern sweep, inputs change during sleep
        for (int p = 0; p < 40; p++) begin
            v = RES_W'((p * 32'h1A2B3) ^ (32'hF0F0F >> (p % 8)));
            s = p[0];
            r = p[1];
            res_in = v; sign_in = s; range_in = r;
            wait_clk(N + 6);
            res_in = ~v; sign_in = ~s; range_in = ~r;
            wait_clk(10);
            cs_n = 1'b0;
            wait_clk(4);
            read_word(got);
            check("R5 sweep word", 32'(got), 32'(mk_word(1'b0, s, r, v)));
            cs_n = 1'b1;
            wait_clk(4);
        end

        // R8: abort part-way, new conversion starts
        res_in = 20'h12345; sign_in = 1'b0; range_in = 1'b1;
        wait_clk(N + 6);
        cs_n = 1'b0;
        wait_clk(4);
        for (int i = 0; i < 5; i++) begin
            sck = 1'b1; wait_clk(4);
            sck = 1'b0; wait_clk(4);
        end
        cs_n = 1'b1;
        wait_clk(4);
        check("R9 oe off after abort", 32'(sdo_oe), 32'd0);
        res_in = 20'hFEDCB; sign_in = 1'b1; range_in = 1'b1;
        cs_n = 1'b0;
        wait_clk(4);
        check("R8 busy after abort", 32'(sdo_d), 32'd1);
        wait_clk(N + 4);
        read_word(got);
        check("R8 word after abort", 32'(got), 32'(mk_word(1'b0, 1'b1, 1'b1, 20'hFEDCB)));
        cs_n = 1'b1;
        wait_clk(4);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule